// File: doc/BRIEF.md
# NAND Page DMA Transfer Engine

This block moves one NAND page between the controller's page buffer and system memory. A page is split into two regions: the main data region of a fixed size and a spare region whose length software chooses. Each region has its own memory base address and its own enable, so a transfer can move the data region, the spare region, or both. When both run, the data region goes first.

Software writes the two base addresses, the spare length, a per-region parameter word and the interrupt enable through a small register port. It then writes the control word with the start bit set. The direction bit in that word picks memory-to-flash (program) or flash-to-memory (read). The engine splits each region into memory bursts of 16, 8 or 4 words, as the control word allows, and single words for the tail. It issues one burst command at a time and waits for the memory side to report that the burst has finished. When everything has moved, the start bit reads back 0 and a completion flag is raised. The flag drives the interrupt line if it is enabled, and software clears it by writing 1 to it.

Register word indices: 0 control, 1 data base, 2 spare base, 3 length, 4 parameter, 5 interrupt enable, 6 interrupt status (read only), 7 interrupt clear (write only). Reads of register 7 return 0.

Top module: `nand_page_dma`

## Requirements
- R1: After reset the control register reads 0, irq is low and mem_cmd_valid is low.
- R2: Writing control (index 0) with bit 0 set starts a transfer. While the transfer runs, control bit 0 reads 1. It reads 0 once the transfer has finished.
- R3: The data region runs only when control bit 2 and parameter bit 0 are both set. The spare region runs only when control bit 3 and parameter bit 1 are both set and the spare length is at least one word. When both run, every data-region burst comes before the first spare-region burst. Parameter bits 5:0 read back as written.
- R4: The data region moves DATA_BYTES bytes, starting at the data base (index 1) and at page-buffer offset 0. The spare region starts at the spare base (index 2) and at page-buffer offset DATA_BYTES. It moves length-register bits 27:16 bytes, rounded down to whole words of WORD_BYTES.
- R5: Control bits 4, 5 and 6 allow bursts of 4, 8 and 16 words. Each command uses the largest allowed burst that does not exceed the words left in the region, or a single word if none fits. After each command, the memory address and the buffer offset both advance by beats times WORD_BYTES.
- R6: With control bit 1 set, commands are memory reads (mem_cmd_write = 0). With it clear, commands are memory writes (mem_cmd_write = 1).
- R7: A command stays asserted with unchanged fields until mem_cmd_ready. The next command is issued only after a mem_done pulse.
- R8: On completion, interrupt-status bit 9 (index 6) is set. irq is high while that bit and interrupt-enable bit 9 (index 5) are both set. Writing 1 to bit 9 of index 7 clears the status bit.
- R9: A write to the control register while a transfer is running has no effect: the transfer continues unchanged and the control fields keep their values.
- R10: Control bits 9:8 drive nand_cs and control bit 7 drives long_addr. Both hold their values until the next accepted control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_cmd_valid | output | 1 | Burst command pending |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_cmd_addr | output | ADDR_W | Memory byte address of the burst |
| mem_cmd_beats | output | 5 | Burst length in words (1, 4, 8, 16) |
| mem_cmd_buf_off | output | OFF_W | Page-buffer byte offset of the burst |
| mem_done | input | 1 | Pulse: accepted burst has completed |
| nand_cs | output | 2 | Target chip select from control |
| long_addr | output | 1 | Long address form from control |
| irq | output | 1 | DMA completion interrupt |

## Verification
On every cycle, the assertions check three things: each burst length is one of the four legal sizes, a pending command holds its fields until it is accepted, and no data-region burst reaches past the end of the data region. They also check that the completion pulse always sets the status flag. Other behaviour can only be shown by the bench's scenarios, which cover every combination of burst allowances, region enables and spare lengths. These include the exact burst order and its sizes, the data-before-spare ordering, how short spare lengths are rounded down, the direction flag, start writes that are ignored while a transfer runs, and the interplay of the interrupt enable and clear.

// File: rtl/npd_pkg.sv
package npd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LOAD_D = 3'd1,
      ST_LOAD_S = 3'd2,
      ST_ISSUE  = 3'd3,
      ST_WAIT   = 3'd4
   } npd_state_t;

   localparam logic [2:0] RIX_CTRL  = 3'd0;
   localparam logic [2:0] RIX_DBASE = 3'd1;
   localparam logic [2:0] RIX_SBASE = 3'd2;
   localparam logic [2:0] RIX_LEN   = 3'd3;
   localparam logic [2:0] RIX_PARAM = 3'd4;
   localparam logic [2:0] RIX_IEN   = 3'd5;
   localparam logic [2:0] RIX_ISTAT = 3'd6;
   localparam logic [2:0] RIX_ICLR  = 3'd7;

   localparam int DONE_BIT = 9;
   localparam int LEN_LSB  = 16;

   typedef struct packed {
      logic [1:0] cs;
      logic       long_addr;
      logic [2:0] burst_en;
      logic       spare_area;
      logic       data_area;
      logic       to_flash;
   } npd_ctrl_t;

endpackage

// File: rtl/npd_burst_pick.sv
module npd_burst_pick #(
   parameter int CNT_W = 11
) (
   input  logic [CNT_W-1:0] left,
   input  logic [2:0]       allow,
   output logic [4:0]       beats
);
   logic [2:0] fits;

   generate
      for (genvar t = 0; t < 3; t++) begin : g_tier
         localparam int SIZE = 4 << t;
         assign fits[t] = allow[t] && (left >= CNT_W'(SIZE));
      end
   endgenerate

   always_comb begin
      if (fits[2])      beats = 5'd16;
      else if (fits[1]) beats = 5'd8;
      else if (fits[0]) beats = 5'd4;
      else              beats = 5'd1;
   end
endmodule

// File: rtl/npd_regs.sv
module npd_regs
   import npd_pkg::*;
#(
   parameter int LEN_W  = 12,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              busy,
   input  logic              dma_done,
   output logic              start,
   output npd_ctrl_t         ctrl,
   output logic [5:0]        param,
   output logic [ADDR_W-1:0] data_base,
   output logic [ADDR_W-1:0] spare_base,
   output logic [LEN_W-1:0]  spare_len,
   output logic              irq
);
   logic int_en;
   logic int_stat;
   logic ctrl_wr;

   assign ctrl_wr = reg_wr && (reg_addr == RIX_CTRL) && !busy;
   assign start   = ctrl_wr && reg_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl       <= '0;
         param      <= '0;
         data_base  <= '0;
         spare_base <= '0;
         spare_len  <= '0;
         int_en     <= 1'b0;
      end else if (reg_wr) begin
         case (reg_addr)
            RIX_CTRL:  if (!busy) ctrl <= reg_wdata[9:1];
            RIX_DBASE: data_base  <= reg_wdata[ADDR_W-1:0];
            RIX_SBASE: spare_base <= reg_wdata[ADDR_W-1:0];
            RIX_LEN:   spare_len  <= reg_wdata[LEN_LSB +: LEN_W];
            RIX_PARAM: param      <= reg_wdata[5:0];
            RIX_IEN:   int_en     <= reg_wdata[DONE_BIT];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         int_stat <= 1'b0;
      else if (dma_done)
         int_stat <= 1'b1;
      else if (reg_wr && reg_addr == RIX_ICLR && reg_wdata[DONE_BIT])
         int_stat <= 1'b0;
   end

   assign irq = int_stat && int_en;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RIX_CTRL:  reg_rdata[9:0] = {ctrl, busy};
         RIX_DBASE: reg_rdata[ADDR_W-1:0] = data_base;
         RIX_SBASE: reg_rdata[ADDR_W-1:0] = spare_base;
         RIX_LEN:   reg_rdata[LEN_LSB +: LEN_W] = spare_len;
         RIX_PARAM: reg_rdata[5:0] = param;
         RIX_IEN:   reg_rdata[DONE_BIT] = int_en;
         RIX_ISTAT: reg_rdata[DONE_BIT] = int_stat;
         default:   reg_rdata = '0;
      endcase
   end

   // R8
   done_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done |=> int_stat);

endmodule

// File: rtl/npd_seq.sv
module npd_seq
   import npd_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int DATA_BYTES = 2048,
   parameter int LEN_W      = 12,
   parameter int OFF_W      = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              data_go,
   input  logic              spare_go,
   input  logic [2:0]        burst_en,
   input  logic              to_flash,
   input  logic [ADDR_W-1:0] data_base,
   input  logic [ADDR_W-1:0] spare_base,
   input  logic [LEN_W-1:0]  spare_len,
   output logic              busy,
   output logic              dma_done,
   output logic              mem_cmd_valid,
   input  logic              mem_cmd_ready,
   output logic              mem_cmd_write,
   output logic [ADDR_W-1:0] mem_cmd_addr,
   output logic [4:0]        mem_cmd_beats,
   output logic [OFF_W-1:0]  mem_cmd_buf_off,
   input  logic              mem_done
);
   localparam int WB_LOG     = $clog2(WORD_BYTES);
   localparam int DATA_WORDS = DATA_BYTES / WORD_BYTES;
   localparam int SPARE_MAX  = (1 << LEN_W) / WORD_BYTES;
   localparam int MAX_WORDS  = (DATA_WORDS > SPARE_MAX) ? DATA_WORDS : SPARE_MAX;
   localparam int LEFT_W     = $clog2(MAX_WORDS + 1);

   npd_state_t          state;
   logic [LEFT_W-1:0]   left;
   logic                in_spare;
   logic [LEFT_W-1:0]   spare_words;
   logic                spare_runs;
   logic [ADDR_W-1:0]   step;

   assign spare_words = LEFT_W'(spare_len >> WB_LOG);
   assign spare_runs  = spare_go && (spare_words != '0);
   assign step        = ADDR_W'(mem_cmd_beats) << WB_LOG;

   npd_burst_pick #(.CNT_W(LEFT_W)) u_pick (
      .left  (left),
      .allow (burst_en),
      .beats (mem_cmd_beats)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state           <= ST_IDLE;
         left            <= '0;
         in_spare        <= 1'b0;
         mem_cmd_addr    <= '0;
         mem_cmd_buf_off <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) state <= ST_LOAD_D;
            ST_LOAD_D: begin
               if (data_go) begin
                  mem_cmd_addr    <= data_base;
                  mem_cmd_buf_off <= '0;
                  left            <= LEFT_W'(DATA_WORDS);
                  in_spare        <= 1'b0;
                  state           <= ST_ISSUE;
               end else begin
                  state <= ST_LOAD_S;
               end
            end
            ST_LOAD_S: begin
               if (spare_runs) begin
                  mem_cmd_addr    <= spare_base;
                  mem_cmd_buf_off <= OFF_W'(DATA_BYTES);
                  left            <= spare_words;
                  in_spare        <= 1'b1;
                  state           <= ST_ISSUE;
               end else begin
                  state <= ST_IDLE;
               end
            end
            ST_ISSUE: begin
               if (mem_cmd_ready) begin
                  mem_cmd_addr    <= mem_cmd_addr + step;
                  mem_cmd_buf_off <= mem_cmd_buf_off + OFF_W'(step);
                  left            <= left - LEFT_W'(mem_cmd_beats);
                  state           <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (mem_done) begin
                  if (left != '0)    state <= ST_ISSUE;
                  else if (!in_spare) state <= ST_LOAD_S;
                  else               state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy          = (state != ST_IDLE);
   assign mem_cmd_valid = (state == ST_ISSUE);
   assign mem_cmd_write = !to_flash;
   assign dma_done      = ((state == ST_LOAD_S) && !spare_runs) ||
                          ((state == ST_WAIT) && mem_done && (left == '0) && in_spare);

   // R5
   beats_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cmd_valid |-> (mem_cmd_beats == 5'd1 || mem_cmd_beats == 5'd4 ||
                         mem_cmd_beats == 5'd8 || mem_cmd_beats == 5'd16));

   // R7
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd_valid && !mem_cmd_ready) |=>
         (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_beats) &&
          $stable(mem_cmd_buf_off)));

   // R4
   data_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd_valid && !in_spare) |->
         (int'(mem_cmd_buf_off) + int'(mem_cmd_beats) * WORD_BYTES <= DATA_BYTES));

endmodule

// File: rtl/nand_page_dma.sv
module nand_page_dma
   import npd_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int DATA_BYTES = 2048,
   parameter int LEN_W      = 12,
   parameter int OFF_W      = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_cmd_valid,
   input  logic              mem_cmd_ready,
   output logic              mem_cmd_write,
   output logic [ADDR_W-1:0] mem_cmd_addr,
   output logic [4:0]        mem_cmd_beats,
   output logic [OFF_W-1:0]  mem_cmd_buf_off,
   input  logic              mem_done,
   output logic [1:0]        nand_cs,
   output logic              long_addr,
   output logic              irq
);
   generate
      if ((WORD_BYTES & (WORD_BYTES - 1)) != 0 || WORD_BYTES < 1)
         begin : g_bad_word
            $error("WORD_BYTES must be a power of two");
         end
      if (DATA_BYTES % WORD_BYTES != 0 || DATA_BYTES < WORD_BYTES)
         begin : g_bad_data
            $error("DATA_BYTES must be a positive multiple of WORD_BYTES");
         end
      if ((1 << OFF_W) < DATA_BYTES + (1 << LEN_W))
         begin : g_bad_off
            $error("OFF_W too narrow for the page buffer");
         end
      if (ADDR_W > 32 || LEN_W > 16)
         begin : g_bad_width
            $error("ADDR_W or LEN_W exceeds the register width");
         end
   endgenerate

   npd_ctrl_t         ctrl;
   logic [5:0]        param;
   logic [ADDR_W-1:0] data_base;
   logic [ADDR_W-1:0] spare_base;
   logic [LEN_W-1:0]  spare_len;
   logic              busy;
   logic              dma_done;
   logic              start;

   npd_regs #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .busy       (busy),
      .dma_done   (dma_done),
      .start      (start),
      .ctrl       (ctrl),
      .param      (param),
      .data_base  (data_base),
      .spare_base (spare_base),
      .spare_len  (spare_len),
      .irq        (irq)
   );

   npd_seq #(
      .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .DATA_BYTES(DATA_BYTES),
      .LEN_W(LEN_W), .OFF_W(OFF_W)
   ) u_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .start           (start),
      .data_go         (ctrl.data_area && param[0]),
      .spare_go        (ctrl.spare_area && param[1]),
      .burst_en        (ctrl.burst_en),
      .to_flash        (ctrl.to_flash),
      .data_base       (data_base),
      .spare_base      (spare_base),
      .spare_len       (spare_len),
      .busy            (busy),
      .dma_done        (dma_done),
      .mem_cmd_valid   (mem_cmd_valid),
      .mem_cmd_ready   (mem_cmd_ready),
      .mem_cmd_write   (mem_cmd_write),
      .mem_cmd_addr    (mem_cmd_addr),
      .mem_cmd_beats   (mem_cmd_beats),
      .mem_cmd_buf_off (mem_cmd_buf_off),
      .mem_done        (mem_done)
   );

   assign nand_cs   = ctrl.cs;
   assign long_addr = ctrl.long_addr;

   // R10
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(nand_cs) && $stable(long_addr)));

endmodule

// File: tb/nand_page_dma_bench.sv
module nand_page_dma_bench;
   localparam int DB = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_cmd_valid;
   logic        mem_cmd_ready = 1'b0;
   logic        mem_cmd_write;
   logic [31:0] mem_cmd_addr;
   logic [4:0]  mem_cmd_beats;
   logic [12:0] mem_cmd_buf_off;
   logic        mem_done = 1'b0;
   logic [1:0]  nand_cs;
   logic        long_addr;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   nand_page_dma #(.DATA_BYTES(DB)) u_nand_page_dma (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
      .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
      .mem_cmd_beats(mem_cmd_beats), .mem_cmd_buf_off(mem_cmd_buf_off),
      .mem_done(mem_done), .nand_cs(nand_cs), .long_addr(long_addr), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic int pick(input int left, input logic [2:0] en);
      if (en[2] && left >= 16) return 16;
      if (en[1] && left >= 8)  return 8;
      if (en[0] && left >= 4)  return 4;
      return 1;
   endfunction

   task automatic wait_valid(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (mem_cmd_valid) begin ok = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   // Walks one region, checking each command (R4, R5, R6, R7, R9, R10)
   task automatic do_region(input logic [31:0] base, input int words, input int off0,
                            input logic [2:0] en, input bit dir,
                            input logic [31:0] ctrl_w, inout bit first);
      int left = words;
      logic [31:0] a = base;
      int o = off0;
      while (left > 0) begin
         int b = pick(left, en);
         bit ok;
         wait_valid(ok);
         chk(ok, "R7 command issued", 64'(mem_cmd_valid), 64'd1);
         if (!ok) return;
         chk(mem_cmd_addr == a, "R4 address", 64'(mem_cmd_addr), 64'(a));
         chk(int'(mem_cmd_buf_off) == o, "R4 buffer offset", 64'(mem_cmd_buf_off), 64'(o));
         chk(int'(mem_cmd_beats) == b, "R5 burst length", 64'(mem_cmd_beats), 64'(b));
         chk(mem_cmd_write == !dir, "R6 direction", 64'(mem_cmd_write), 64'(!dir));
         if (first) begin
            first = 1'b0;
            wr(3'd0, ctrl_w ^ 32'h0000_0302);
            chk(mem_cmd_valid && mem_cmd_addr == a && int'(mem_cmd_beats) == b,
                "R7 hold until ready", 64'(mem_cmd_addr), 64'(a));
            chk(nand_cs == ctrl_w[9:8] && mem_cmd_write == !dir,
                "R9 write while busy ignored", 64'(nand_cs), 64'(ctrl_w[9:8]));
         end
         mem_cmd_ready = 1'b1;
         @(negedge clk);
         mem_cmd_ready = 1'b0;
         chk(!mem_cmd_valid, "R7 no command before done", 64'(mem_cmd_valid), 64'd0);
         @(negedge clk);
         mem_done = 1'b1;
         @(negedge clk);
         mem_done = 1'b0;
         left -= b;
         a += 32'(b * 4);
         o += b * 4;
      end
   endtask

   initial begin
      logic [31:0] v;
      int run = 0;
      repeat (3) @(negedge clk);
      rd(3'd0, v);
      chk(v == 32'd0, "R1 control after reset", 64'(v), 64'd0);
      chk(!irq && !mem_cmd_valid, "R1 outputs after reset", 64'({irq, mem_cmd_valid}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int bu = 0; bu < 8; bu++) begin
         for (int cb = 0; cb < 4; cb++) begin
            for (int si = 0; si < 3; si++) begin
               int sl = (si == 0) ? 0 : (si == 1) ? 22 : 60;
               bit dir = bu[0] ^ cb[0];
               bit gate_param = bu[1];
               bit ien = cb[1];
               logic [1:0] cs = 2'(cb);
               logic [31:0] db = 32'h4000_0000 + 32'(run) * 32'h100;
               logic [31:0] sb = 32'h8000_0000 + 32'(run) * 32'h40;
               logic [1:0] area = gate_param ? 2'b11 : 2'(cb);
               logic [1:0] prm  = gate_param ? 2'(cb) : 2'b11;
               bit d_on = cb[0];
               bit s_on = cb[1] && (sl / 4 > 0);
               logic [31:0] ctrl_w;
               bit first = 1'b1;
               ctrl_w = 32'd1 | (32'(dir) << 1) | (32'(area) << 2) | (32'(bu) << 4) |
                        (32'(si == 2) << 7) | (32'(cs) << 8);
               wr(3'd1, db);
               wr(3'd2, sb);
               wr(3'd3, 32'(sl) << 16);
               wr(3'd4, {26'd0, 4'hA, prm});
               wr(3'd5, 32'(ien) << 9);
               if (run == 0) begin
                  rd(3'd4, v);
                  chk(v == {26'd0, 4'hA, prm}, "R3 parameter readback", 64'(v), 64'({4'hA, prm}));
                  rd(3'd3, v);
                  chk(v == 32'(sl) << 16, "R4 length readback", 64'(v), 64'(32'(sl) << 16));
               end
               wr(3'd0, ctrl_w);
               rd(3'd0, v);
               chk(v[0] == 1'b1, "R2 start reads 1 while running", 64'(v[0]), 64'd1);
               chk(nand_cs == cs && long_addr == (si == 2), "R10 select outputs",
                   64'({nand_cs, long_addr}), 64'({cs, 1'(si == 2)}));
               if (d_on) do_region(db, DB / 4, 0, 3'(bu), dir, ctrl_w, first);
               if (s_on) do_region(sb, sl / 4, DB, 3'(bu), dir, ctrl_w, first);
               for (int k = 0; k < 6; k++) begin
                  rd(3'd0, v);
                  if (!v[0]) break;
                  @(negedge clk);
               end
               rd(3'd0, v);
               chk(v[0] == 1'b0, "R2 start reads 0 when done", 64'(v[0]), 64'd0);
               chk(!mem_cmd_valid, "R3 no extra region commands", 64'(mem_cmd_valid), 64'd0);
               rd(3'd6, v);
               chk(v[9] == 1'b1, "R8 status set on completion", 64'(v[9]), 64'd1);
               chk(irq == ien, "R8 irq follows enable", 64'(irq), 64'(ien));
               wr(3'd7, 32'h200);
               rd(3'd6, v);
               chk(v[9] == 1'b0 && !irq, "R8 clear by write one", 64'({v[9], irq}), 64'd0);
               run++;
            end
         end
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule